// File: doc/BRIEF.md
# Keyed Watchdog and Software Reset Generator

This block produces a chip-internal reset pulse from two sources: a watchdog counter that expires when software stops servicing it, and a software request. Software drives both through a small register write port. Each action is protected by a two-byte key. The watchdog restarts only when its register receives the correct pair of bytes in order. A software reset fires only when a second register receives a different pair of bytes in order. Random or runaway writes therefore cannot restart the watchdog or reset the chip by accident.

Either source starts a reset pulse of fixed length. Each source also sets its own cause flag, so software can tell after reset which source acted. The flags survive the pulse that they describe. Only the external reset or an explicit software clear removes them. The watchdog timeout is a power of two of clock cycles, picked by a 3-bit select input.

Top module: `keyed_reset_gen`

## Requirements
- R1: Each trigger causes `rst_pulse` to rise in the cycle after the triggering clock edge. The pulse stays high for exactly 16 cycles. A trigger that arrives while the pulse is already high does not lengthen it.
- R2: While `wdt_en` is high, the watchdog counts clock cycles. After 2^(4+`wdt_sel`) counted cycles with no restart, it starts the pulse and sets `cause_wdt`. For example, `wdt_sel`=0 gives 16 cycles and `wdt_sel`=1 gives 32 cycles.
- R3: Writing 0x1E and then 0xE1 to address 0 (the restart register) clears the watchdog count. The count starts again from zero after the second byte.
- R4: Writing 0x5A and then 0xA5 to address 1 (the software-reset register) starts the pulse and sets `cause_sw`.
- R5: A write to a key register that breaks the expected order sends that register's tracker back to waiting for the first byte. This covers a wrong value, and it also covers the second byte arriving first. No restart and no reset result.
- R6: A write to any other address between the two bytes of a key sequence leaves that sequence intact.
- R7: Both cause flags survive the pulse. A write to address 2 clears a flag where the data bit is 0: bit 0 clears `cause_wdt` and bit 1 clears `cause_sw`. A 1 in the data leaves the flag as it was. The external reset clears both flags.
- R8: While the pulse is high, the watchdog count is held at zero. After the pulse, counting resumes from zero if `wdt_en` is high.
- R9: While `wdt_en` is low, the watchdog never expires and its count stays at zero.
- R10: After the external reset, `rst_pulse`, `cause_wdt` and `cause_sw` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, synchronous, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Register select: 0 restart, 1 software reset, 2 status |
| wr_data | input | 8 | Write data |
| wdt_en | input | 1 | Watchdog enable |
| wdt_sel | input | 3 | Timeout select; the timeout is 2^(4+sel) cycles |
| rst_pulse | output | 1 | Internal reset pulse, active high, 16 cycles |
| cause_wdt | output | 1 | Set by a watchdog expiry |
| cause_sw | output | 1 | Set by a valid software-reset sequence |

## Verification
The assertions take for granted that `wdt_sel` stays constant while the watchdog is counting. A change of timeout in the middle of a count could make the count jump past its limit. The stimulus changes `wdt_sel` only while the block is in external reset or while `wdt_en` is low.

The pulse-length property assumes that a second trigger during an active pulse is dropped. The bench therefore issues software-reset sequences only after the previous pulse has ended, except in the test where the flags are combined. Writes are applied on the falling clock edge, one per cycle, so the write port always holds a single stable request at each rising edge.

// File: rtl/keyed_rst_pkg.sv
// Package: register addresses, key bytes and status bit positions.
// Assumes: used by every module of the keyed reset generator.
package keyed_rst_pkg;
    localparam int          ADDR_W       = 2;
    localparam int          DATA_W       = 8;
    localparam logic [1:0]  ADDR_KICK    = 2'd0;
    localparam logic [1:0]  ADDR_SWRST   = 2'd1;
    localparam logic [1:0]  ADDR_STATUS  = 2'd2;
    localparam logic [7:0]  KICK_KEY_A   = 8'h1E;
    localparam logic [7:0]  KICK_KEY_B   = 8'hE1;
    localparam logic [7:0]  SWRST_KEY_A  = 8'h5A;
    localparam logic [7:0]  SWRST_KEY_B  = 8'hA5;
    localparam int          STAT_WDT_BIT = 0;
    localparam int          STAT_SW_BIT  = 1;
endpackage

// File: rtl/seq_unlock.sv
// Two-byte key tracker for a single register address.
// What it does: hit is high for one cycle, during the write that supplies
// KEY_B right after KEY_A. Any other write to the same address disarms the
// tracker. Writes to other addresses leave it unchanged.
// Assumes: at most one write per cycle; synchronous active-low reset.
module seq_unlock
    import keyed_rst_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR  = '0,
    parameter logic [DATA_W-1:0] KEY_A = '0,
    parameter logic [DATA_W-1:0] KEY_B = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hit
);
    logic armed;
    logic sel;

    // Decode a write aimed at this tracker.
    assign sel = wr_en && (wr_addr == ADDR);
    // The sequence completes when the armed tracker receives the second key.
    assign hit = sel && armed && (wr_data == KEY_B);

    // Arm on the first key; any other write here returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (sel)     armed <= !armed && (wr_data == KEY_A);
    end

    // R5: a wrong byte to an armed tracker disarms it.
    assert_break_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && armed && wr_data != KEY_B) |=> !armed);
    // R6: writes to other addresses leave the tracker state alone.
    assert_other_addr_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(armed));
endmodule

// File: rtl/wdt_counter.sv
// Watchdog counter with a power-of-two timeout.
// What it does: counts enabled cycles. When the count reaches
// 2^(BASE_LOG2+sel)-1, expire goes high for one cycle and the count restarts.
// kick clears the count. hold (the reset pulse) clears it and stops it.
// Assumes: sel is steady while enable is high.
module wdt_counter #(
    parameter int BASE_LOG2 = 4,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    input  logic             hold,
    output logic             expire
);
    localparam int CW = BASE_LOG2 + (1 << SEL_W);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] shamt;
    logic [CW-1:0] last;

    // Work out the final count value for the selected timeout.
    always_comb begin
        shamt = CW'(BASE_LOG2) + CW'(sel);
        last  = (ONE << shamt) - ONE;
    end

    // Expiry happens on the final counted cycle while running.
    assign expire = enable && !hold && !kick && (cnt == last);

    // Count up, or clear on kick, expiry, hold or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (hold || !enable || kick)   cnt <= '0;
        else if (cnt == last)               cnt <= '0;
        else                                cnt <= cnt + ONE;
    end

    // R8: the count is zero in the cycle after any held cycle.
    assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));
    // R9: a disabled watchdog keeps a zero count and never expires.
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));
    // R3: a restart leaves the count at zero.
    assert_kick_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !hold) |=> (cnt == '0));
endmodule

// File: rtl/rst_pulse_gen.sv
// Fixed-length pulse generator for the internal reset.
// What it does: a trigger while idle raises pulse for exactly LEN cycles,
// starting in the cycle after the trigger. Triggers during a pulse are dropped.
// Assumes: LEN >= 1.
module rst_pulse_gen #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);
    localparam int PW = $clog2(LEN + 1);
    localparam logic [PW-1:0] LEN_V = PW'(LEN);

    logic [PW-1:0] left;
    logic [PW-1:0] run_len;

    assign pulse = (left != '0);

    // Load the length on an idle trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                 left <= '0;
        else if (pulse)             left <= left - PW'(1);
        else if (trigger)           left <= LEN_V;
    end

    // Checker bookkeeping: number of high cycles in the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse)       run_len <= '0;
        else                        run_len <= run_len + PW'(1);
    end

    // R1: every pulse lasts exactly LEN cycles.
    assert_pulse_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> (run_len == LEN_V));
    // R1: a pulse starts only right after an idle trigger.
    assert_pulse_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(trigger));
endmodule

// File: rtl/keyed_reset_gen.sv
// Top level: keyed watchdog plus a software reset, with cause flags.
// What it does: two key trackers decode the restart sequence and the
// software-reset sequence. The watchdog counter and the software request
// share one 16-cycle pulse generator. Sticky flags record which source fired.
// Assumes: one write per cycle; wdt_sel steady while the watchdog counts.
module keyed_reset_gen
    import keyed_rst_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int BASE_LOG2 = 4,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] wdt_sel,
    output logic             rst_pulse,
    output logic             cause_wdt,
    output logic             cause_sw
);
    logic kick_hit;
    logic sw_hit;
    logic expire;
    logic stat_wr;

    // Tracker for the watchdog restart key.
    seq_unlock #(.ADDR(ADDR_KICK), .KEY_A(KICK_KEY_A), .KEY_B(KICK_KEY_B)) u_kick_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hit(kick_hit)
    );

    // Tracker for the software-reset key.
    seq_unlock #(.ADDR(ADDR_SWRST), .KEY_A(SWRST_KEY_A), .KEY_B(SWRST_KEY_B)) u_sw_key (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hit(sw_hit)
    );

    // Watchdog, frozen while the pulse it may have caused is active.
    wdt_counter #(.BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .enable(wdt_en), .sel(wdt_sel),
        .kick(kick_hit), .hold(rst_pulse), .expire(expire)
    );

    // Shared fixed-length reset pulse.
    rst_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trigger(expire || sw_hit), .pulse(rst_pulse)
    );

    assign stat_wr = wr_en && (wr_addr == ADDR_STATUS);

    // Sticky cause flags: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_wdt <= 1'b0;
            cause_sw  <= 1'b0;
        end else begin
            cause_wdt <= expire || (cause_wdt && !(stat_wr && !wr_data[STAT_WDT_BIT]));
            cause_sw  <= sw_hit || (cause_sw  && !(stat_wr && !wr_data[STAT_SW_BIT]));
        end
    end

    // R2: the watchdog flag rises together with a new pulse.
    assert_wdt_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_wdt) |-> $rose(rst_pulse));
    // R4: the software flag rises only while a pulse is high.
    assert_sw_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_sw) |-> rst_pulse);
    // R7: without a status write, the flags never drop.
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && cause_wdt && cause_sw) |=> (cause_wdt && cause_sw));
endmodule

// File: tb/keyed_reset_gen_bench.sv
`timescale 1ns/1ps
// Bench: a table of software-reset key writes, then directed tests for the
// watchdog, the flags and reset. Inputs change on the falling edge.
module keyed_reset_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdt_en = 1'b0;
    logic [2:0] wdt_sel = '0;
    logic       rst_pulse, cause_wdt, cause_sw;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  pulse_seen = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    keyed_reset_gen u_keyed_reset_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wdt_en(wdt_en), .wdt_sel(wdt_sel), .rst_pulse(rst_pulse),
        .cause_wdt(cause_wdt), .cause_sw(cause_sw)
    );

    // Sticky monitor of any pulse cycle.
    always @(negedge clk) if (rst_pulse) pulse_seen <= 1'b1;

    // Table entry: {expected pulse, address[1:0], data[7:0]}.
    localparam logic [10:0] VEC [13] = '{
        {1'b0, 2'd1, 8'h5A}, {1'b1, 2'd1, 8'hA5},   // R4 valid sequence
        {1'b0, 2'd1, 8'hA5},                        // R5 second byte first
        {1'b0, 2'd1, 8'h5A}, {1'b0, 2'd1, 8'h00},   // R5 wrong value
        {1'b0, 2'd1, 8'hA5},
        {1'b0, 2'd1, 8'h5A}, {1'b0, 2'd0, 8'h1E},   // R6 other address between
        {1'b0, 2'd2, 8'h03}, {1'b1, 2'd1, 8'hA5},
        {1'b0, 2'd1, 8'h5A}, {1'b0, 2'd1, 8'h5A},   // R5 repeated first byte
        {1'b0, 2'd1, 8'hA5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wdt_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count falling edges until the pulse is seen, up to a limit.
    task automatic wait_pulse(output int n, input int max);
        n = 0;
        while (!rst_pulse && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Count the cycles the pulse stays high, starting from a high sample.
    task automatic pulse_len(output int n);
        n = 0;
        while (rst_pulse && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        // R10: state after the external reset.
        check(!rst_pulse && !cause_wdt && !cause_sw, "R10",
              {rst_pulse, cause_wdt, cause_sw}, 0);

        // Table walk: software-reset key handling.
        for (int i = 0; i < 13; i++) begin
            wr(VEC[i][9:8], VEC[i][7:0]);
            check(rst_pulse == VEC[i][10], $sformatf("R4/R5/R6 vec%0d", i),
                  rst_pulse, VEC[i][10]);
            if (VEC[i][10]) begin
                pulse_len(n);
                check(n == 16, "R1 sw pulse length", n, 16);
                check(cause_sw && !cause_wdt, "R4 sw flag", {cause_wdt, cause_sw}, 1);
                wr(2'd2, 8'h00);
                check(!cause_sw, "R7 clear by zero", cause_sw, 0);
            end
        end

        // R2/R8: timeout at 16 cycles, a 16-cycle pulse, then the next timeout.
        do_reset();
        wdt_sel = 3'd0;
        wdt_en = 1'b1;
        wait_pulse(n, 100);
        check(n == 16, "R2 timeout sel0", n, 16);
        check(cause_wdt && !cause_sw, "R2 wdt flag", {cause_wdt, cause_sw}, 2);
        pulse_len(n);
        check(n == 16, "R1 wdt pulse length", n, 16);
        check(cause_wdt, "R7 flag survives pulse", cause_wdt, 1);
        wait_pulse(n, 100);
        check(n == 16, "R8 resume after pulse", n, 16);
        pulse_len(n);

        // R2: a larger select gives 64 cycles.
        do_reset();
        wdt_sel = 3'd2;
        wdt_en = 1'b1;
        wait_pulse(n, 200);
        check(n == 64, "R2 timeout sel2", n, 64);

        // R3: regular restarts keep the watchdog quiet; expiry 32 after the last one.
        do_reset();
        wdt_sel = 3'd1;
        wdt_en = 1'b1;
        pulse_seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            repeat (20) @(negedge clk);
            wr(2'd0, 8'h1E);
            wr(2'd0, 8'hE1);
        end
        check(!pulse_seen, "R3 restart holds off", pulse_seen, 0);
        wait_pulse(n, 100);
        check(n == 32, "R3 count from restart", n, 32);

        // R5: wrong order does not restart the watchdog.
        do_reset();
        wdt_sel = 3'd0;
        wdt_en = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'hE1);
        wr(2'd0, 8'h1E);
        wait_pulse(n, 100);
        check(n == 10, "R5 bad order no restart", n, 10);

        // R9: a disabled watchdog never expires.
        do_reset();
        wdt_sel = 3'd0;
        pulse_seen = 1'b0;
        repeat (200) @(negedge clk);
        check(!pulse_seen && !cause_wdt, "R9 disabled", pulse_seen, 0);

        // R7: combined flags, selective clear, ones kept, reset clears.
        do_reset();
        wdt_en = 1'b1;
        wait_pulse(n, 100);
        wdt_en = 1'b0;
        pulse_len(n);
        wr(2'd1, 8'h5A);
        wr(2'd1, 8'hA5);
        pulse_len(n);
        check(cause_wdt && cause_sw, "R7 both flags", {cause_wdt, cause_sw}, 3);
        wr(2'd2, 8'h02);
        check(!cause_wdt && cause_sw, "R7 clear wdt only", {cause_wdt, cause_sw}, 1);
        wr(2'd2, 8'hFF);
        check(cause_sw, "R7 ones ignored", cause_sw, 1);
        do_reset();
        check(!cause_wdt && !cause_sw, "R7 cleared by reset", {cause_wdt, cause_sw}, 0);

        summary();
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule